// File: doc/BRIEF.md
# Programmed I/O Cycle Timer

This block runs one programmed I/O transfer on a parallel disk interface. A one-cycle start pulse, taken while the block is idle, latches a direction select, a timing mode and a write word. A single counter then steps through the transfer. The block drives the read or write strobe for a window of counts set by the mode, enables the data bus for the whole of a write, and captures the device's data word at the end of a read. It finishes with a one-cycle done pulse.

The device ready line is sampled at the last count of the strobe window. While ready is low, the counter holds and the strobe stays asserted. The hold is capped at 1250 ns, which is 125 cycles at the default 10 ns clock. If ready is still low at the cap, the transfer completes anyway and a timeout flag is raised. Each mode has a fixed set of counts, and higher mode numbers give shorter transfers.

Top module: `pio_cycle_timer`

## Requirements
- R1: During and after reset, busy, both strobes, bus enable, done and timeout are low and the captured read word is zero.
- R2: A start pulse while idle is accepted at that clock edge. Busy then stays high for END+1 cycles when ready never holds the transfer. The (strobe-on, strobe-off, END) counts per mode are: mode 0 (7,36,67), mode 1 (5,29,45), mode 2 (3,23,33), mode 3 (3,11,23), mode 4 (2,9,15).
- R3: The direction input is 1 for a write and 0 for a read. Only the strobe of the latched direction is ever asserted. It first goes high strobe-on cycles after the accepting edge and stays high for strobe-off minus strobe-on plus one cycles.
- R4: A mode number of 5, 6 or 7 uses the mode 4 counts.
- R5: Ready is sampled when the count equals strobe-off. Each low sample holds the count for one cycle, which lengthens the strobe and busy by one cycle each.
- R6: At most 125 hold cycles occur. If ready is still low after the 125th, the transfer proceeds and the timeout flag sets. The flag stays set until the next accepted start. A transfer held exactly 125 cycles that then sees ready high does not set the flag.
- R7: The bus enable is high on every busy cycle of a write and never during a read. The bus output carries the latched write word.
- R8: On a read, the read word is captured from the bus at the edge that leaves the strobe-off count. A write leaves the captured word unchanged.
- R9: Done is high for exactly one cycle, the first cycle after busy falls.
- R10: A start pulse while busy is ignored. The direction, mode and length of the running transfer do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse |
| write_i | input | 1 | 1 = write transfer, 0 = read transfer |
| mode_i | input | 3 | Timing mode number |
| wdata_i | input | DATA_W | Word to write |
| dev_ready_i | input | 1 | Device ready line |
| bus_rdata_i | input | DATA_W | Data bus input from device |
| rd_strobe_o | output | 1 | Read strobe, active high |
| wr_strobe_o | output | 1 | Write strobe, active high |
| bus_wdata_o | output | DATA_W | Data bus output word |
| bus_oe_o | output | 1 | Data bus output enable |
| rdata_o | output | DATA_W | Captured read word |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Transfer in progress |
| timeout_o | output | 1 | Ready wait cap was reached |

## Verification
Every mode is run in both directions with four ready profiles: no hold, a short hold, a hold of exactly the cap, and a hold one cycle past the cap. Together these separate the per-mode counts, the stall arithmetic and the cap boundary. The device bus carries a different word on each strobe cycle and a complement word outside the strobe, so a capture one edge early or late is visible. Further runs cover the out-of-range mode numbers, a start pulse in the middle of a transfer, and writes that follow reads, to show that the captured word survives a write.

// File: rtl/pio_timer_pkg.sv
// Shared types for the programmed I/O cycle timer.
// Assumes counts fit in CNT_W bits and mode numbers in MODE_W bits.
package pio_timer_pkg;
    localparam int CNT_W     = 7;
    localparam int MODE_W    = 3;
    localparam int NUM_MODES = 5;

    typedef struct packed {
        logic [CNT_W-1:0] strobe_on;
        logic [CNT_W-1:0] strobe_off;
        logic [CNT_W-1:0] last;
    } pio_counts_t;
endpackage

// File: rtl/pio_mode_table.sv
// Maps a mode number to its counts. Mode numbers past the top mode
// fall back to the fastest mode. Purely combinational.
module pio_mode_table
    import pio_timer_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output pio_counts_t       counts_o
);
    // Per-mode lookup, out-of-range numbers take the fastest set.
    always_comb begin
        case (mode_i)
            MODE_W'(0): counts_o = '{strobe_on: CNT_W'(7), strobe_off: CNT_W'(36), last: CNT_W'(67)};
            MODE_W'(1): counts_o = '{strobe_on: CNT_W'(5), strobe_off: CNT_W'(29), last: CNT_W'(45)};
            MODE_W'(2): counts_o = '{strobe_on: CNT_W'(3), strobe_off: CNT_W'(23), last: CNT_W'(33)};
            MODE_W'(3): counts_o = '{strobe_on: CNT_W'(3), strobe_off: CNT_W'(11), last: CNT_W'(23)};
            default:    counts_o = '{strobe_on: CNT_W'(2), strobe_off: CNT_W'(9),  last: CNT_W'(15)};
        endcase
    end
endmodule

// File: rtl/pio_cycle_counter.sv
// Cycle counter: clears on request, else increments when enabled.
// Assumes clear and increment are never needed in the same cycle
// (clear wins if they are).
module pio_cycle_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    logic [W-1:0] count_q;

    // Count register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) count_q <= '0;
        else if (inc_i)        count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;
endmodule

// File: rtl/pio_wait_guard.sv
// Counts the hold cycles spent waiting on the ready line and flags
// when the cap is reached. Assumes clear_i pulses at each new transfer.
module pio_wait_guard #(
    parameter int LIMIT = 125,
    parameter int W     = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         wait_i,
    output logic         limit_o,
    output logic [W-1:0] count_o
);
    logic [W-1:0] count_q;

    assign limit_o = (count_q == W'(LIMIT));

    // Hold-cycle counter, saturating at the cap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)      count_q <= '0;
        else if (wait_i && !limit_o) count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;
endmodule

// File: rtl/pio_cycle_timer.sv
// Runs one programmed I/O transfer: latches direction, mode and write
// word on an idle start pulse, steps a counter through the mode's
// counts, stalls on a low ready line at the strobe-off count up to a
// fixed cap, captures read data and pulses done at the end.
// Assumes start_i is a single-cycle pulse synchronous to clk.
module pio_cycle_timer
    import pio_timer_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 10,
    parameter int WAIT_LIMIT_NS = 1250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              write_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              dev_ready_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              rd_strobe_o,
    output logic              wr_strobe_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_oe_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              timeout_o
);
    localparam int WAIT_CYC = WAIT_LIMIT_NS / CLK_PERIOD_NS;
    localparam int WAIT_W   = $clog2(WAIT_CYC + 1);

    logic              busy_q;
    logic              write_q;
    logic [MODE_W-1:0] mode_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic              timeout_q;

    pio_counts_t       counts;
    logic [CNT_W-1:0]  cnt;
    logic [WAIT_W-1:0] wait_cnt;
    logic              limit_hit;
    logic              start_acc;
    logic              at_off;
    logic              at_last;
    logic              ready_low;
    logic              stall;
    logic              expire;
    logic              strobe_win;

    pio_mode_table u_table (
        .mode_i   (mode_q),
        .counts_o (counts)
    );

    assign start_acc = start_i && !busy_q;
    assign at_off    = busy_q && (cnt == counts.strobe_off);
    assign at_last   = busy_q && (cnt == counts.last);
    assign ready_low = at_off && !dev_ready_i;
    assign stall     = ready_low && !limit_hit;
    assign expire    = ready_low && limit_hit;

    pio_cycle_counter #(.W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_acc || at_last),
        .inc_i   (busy_q && !stall && !at_last),
        .count_o (cnt)
    );

    pio_wait_guard #(.LIMIT(WAIT_CYC), .W(WAIT_W)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_acc),
        .wait_i  (ready_low),
        .limit_o (limit_hit),
        .count_o (wait_cnt)
    );

    // Busy flag: set on an accepted start, cleared at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (start_acc) busy_q <= 1'b1;
        else if (at_last)   busy_q <= 1'b0;
    end

    // Transfer parameters, latched only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            mode_q  <= '0;
            wdata_q <= '0;
        end else if (start_acc) begin
            write_q <= write_i;
            mode_q  <= mode_i;
            wdata_q <= wdata_i;
        end
    end

    // Read capture on the edge that leaves the strobe-off count.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rdata_q <= '0;
        else if (at_off && !stall && !write_q) rdata_q <= bus_rdata_i;
    end

    // One-cycle done pulse after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= at_last;
    end

    // Timeout flag: set when the cap forces progress, cleared on start.
    always_ff @(posedge clk) begin
        if (!rst_n)         timeout_q <= 1'b0;
        else if (start_acc) timeout_q <= 1'b0;
        else if (expire)    timeout_q <= 1'b1;
    end

    assign strobe_win  = busy_q && (cnt >= counts.strobe_on) && (cnt <= counts.strobe_off);
    assign rd_strobe_o = strobe_win && !write_q;
    assign wr_strobe_o = strobe_win && write_q;
    assign bus_oe_o    = busy_q && write_q;
    assign bus_wdata_o = wdata_q;
    assign rdata_o     = rdata_q;
    assign done_o      = done_q;
    assign busy_o      = busy_q;
    assign timeout_o   = timeout_q;
endmodule

// File: rtl/pio_cycle_timer_chk.sv
// Property checker for pio_cycle_timer, attached by bind below.
module pio_cycle_timer_chk #(
    parameter int WAIT_CYC = 125,
    parameter int WAIT_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              rd_strobe_o,
    input logic              wr_strobe_o,
    input logic              bus_oe_o,
    input logic              done_o,
    input logic              timeout_o,
    input logic              write_q,
    input logic [WAIT_W-1:0] wait_cnt
);
    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe_o && wr_strobe_o));

    // R7
    oe_not_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> !rd_strobe_o);

    // R7
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |=> (bus_oe_o || !busy_o));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(write_q) && (busy_o || done_o)));

    // R6
    wait_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= WAIT_W'(WAIT_CYC));

    // R6
    timeout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !(start_i && !busy_o)) |=> timeout_o);
endmodule

bind pio_cycle_timer pio_cycle_timer_chk #(.WAIT_CYC(WAIT_CYC), .WAIT_W(WAIT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .rd_strobe_o (rd_strobe_o),
    .wr_strobe_o (wr_strobe_o),
    .bus_oe_o    (bus_oe_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o),
    .write_q     (write_q),
    .wait_cnt    (wait_cnt)
);

// File: tb/test_pio_cycle_timer.sv
// Sweep bench for pio_cycle_timer: every mode, both directions and
// four ready-hold profiles, with expected values derived arithmetically.
module test_pio_cycle_timer;
    localparam int DW       = 16;
    localparam int WAIT_CYC = 1250 / 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          write = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic [DW-1:0] wdata = '0;
    logic          ready = 1'b1;
    logic [DW-1:0] rbus = '0;
    logic          rd_s, wr_s, oe, done, busy, tmo;
    logic [DW-1:0] bus_w, rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [DW-1:0] exp_rdata = '0;

    always #5 clk = ~clk;

    pio_cycle_timer #(.DATA_W(DW)) i_pio_cycle_timer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .write_i(write),
        .mode_i(mode), .wdata_i(wdata), .dev_ready_i(ready),
        .bus_rdata_i(rbus), .rd_strobe_o(rd_s), .wr_strobe_o(wr_s),
        .bus_wdata_o(bus_w), .bus_oe_o(oe), .rdata_o(rdata),
        .done_o(done), .busy_o(busy), .timeout_o(tmo)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected counts per mode, from the R2/R4 table.
    function automatic int ref_on(input int m);
        case (m) 0: return 7; 1: return 5; 2: return 3; 3: return 3; default: return 2; endcase
    endfunction
    function automatic int ref_off(input int m);
        case (m) 0: return 36; 1: return 29; 2: return 23; 3: return 11; default: return 9; endcase
    endfunction
    function automatic int ref_last(input int m);
        case (m) 0: return 67; 1: return 45; 2: return 33; 3: return 23; default: return 15; endcase
    endfunction

    task automatic run(input int m, input bit wr, input int extra,
                       input logic [DW-1:0] pat, input logic [DW-1:0] wd,
                       input bit restart, input string tag);
        int a, n, e, nat, h, stall, first, bcnt, scnt, ocnt, dcnt, done_i, wrong, dmis;
        bit exp_to;
        a = ref_on(m); n = ref_off(m); e = ref_last(m);
        nat = n - a + 1;
        h = nat + extra;
        stall = (extra > WAIT_CYC) ? WAIT_CYC : extra;
        exp_to = (extra > WAIT_CYC);
        first = -1; bcnt = 0; scnt = 0; ocnt = 0; dcnt = 0; done_i = -1; wrong = 0; dmis = 0;
        @(negedge clk);
        start = 1'b1; mode = 3'(m); write = wr; wdata = wd; ready = 1'b0; rbus = ~pat;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 600; i++) begin
            if (i > 0) @(negedge clk);
            if (busy) bcnt++;
            if (rd_s || wr_s) begin
                scnt++;
                if (first < 0) first = i;
                if ((wr && rd_s) || (!wr && wr_s)) wrong++;
            end
            if (oe) begin
                ocnt++;
                if (bus_w != wd) dmis++;
            end
            if (done) begin
                dcnt++;
                if (done_i < 0) done_i = i;
            end
            if (done_i >= 0 && i == done_i + 2) break;
            ready = (scnt >= h);
            rbus  = (rd_s || wr_s) ? (pat ^ DW'(scnt)) : ~pat;
            if (restart && i == 5) begin start = 1'b1; write = ~wr; mode = 3'd0; end
            else start = 1'b0;
        end
        start = 1'b0; ready = 1'b1;
        check(bcnt == e + 1 + stall, tag, "R2 busy cycles", bcnt, e + 1 + stall);
        check(first == a, tag, "R3 first strobe cycle", first, a);
        check(scnt == nat + stall, tag, "R3/R5 strobe cycles", scnt, nat + stall);
        check(wrong == 0, tag, "R3 wrong-direction strobes", wrong, 0);
        check(ocnt == (wr ? e + 1 + stall : 0), tag, "R7 bus enable cycles", ocnt, wr ? e + 1 + stall : 0);
        check(dmis == 0, tag, "R7 bus word mismatches", dmis, 0);
        check(dcnt == 1, tag, "R9 done pulses", dcnt, 1);
        check(done_i == e + 1 + stall, tag, "R9 done cycle", done_i, e + 1 + stall);
        if (!wr) exp_rdata = pat ^ DW'(nat + stall);
        check(rdata == exp_rdata, tag, "R8 read word", int'(rdata), int'(exp_rdata));
        check(tmo == exp_to, tag, "R6 timeout flag", int'(tmo), int'(exp_to));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !rd_s && !wr_s && !oe && !done && !tmo, "R1", "reset outputs",
              int'({busy, rd_s, wr_s, oe, done, tmo}), 0);
        check(rdata == '0, "R1", "reset read word", int'(rdata), 0);
        @(negedge clk); rst_n = 1'b1;
        for (int m = 0; m < 5; m++) begin
            for (int w = 0; w < 2; w++) begin
                run(m, w[0], 0,            16'h3C00 + 16'(m * 256 + w), 16'hA500 + 16'(m), 1'b0, "R2");
                run(m, w[0], 3,            16'h5A00 + 16'(m * 16 + w),  16'h0F00 + 16'(m), 1'b0, "R5");
                run(m, w[0], WAIT_CYC,     16'h6600 + 16'(m),           16'h1200 + 16'(m), 1'b0, "R6 at cap");
                run(m, w[0], WAIT_CYC + 1, 16'h7700 + 16'(m),           16'h3400 + 16'(m), 1'b0, "R6 past cap");
            end
        end
        // R4 out-of-range modes use mode 4 counts (task clamps via default)
        for (int m = 5; m < 8; m++) run(m, 1'b0, 2, 16'h1100 + 16'(m), 16'h0, 1'b0, "R4");
        // R10 start pulse mid-transfer is ignored
        run(2, 1'b0, 0, 16'hBEEF, 16'h0, 1'b1, "R10");
        run(4, 1'b1, 1, 16'h0000, 16'hCAFE, 1'b1, "R10");
        // R8 write after read keeps the captured word
        run(1, 1'b1, 0, 16'hFFFF, 16'h1357, 1'b0, "R8");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule